// File: doc/BRIEF.md
# Echoed-Clock ADC Conversion and Readout Sequencer

This block sits on the host side of a 16-bit successive-approximation ADC with a serial output. It paces conversions by raising a conversion-start pulse once every programmable period. When the result is ready it sends a gated burst of exactly sixteen clock pulses to the converter. It then assembles the serial result from the copy of that clock which the converter sends back. The data bit changes on the falling edge of the returned clock and is taken on its next rising edge. The returned clock and data are oversampled in the system clock domain, so the whole block runs on one clock.

Four runtime values set the timing, all counted in system-clock cycles: the conversion period, the width of the start pulse, the delay from the start pulse until the most significant bit is ready, and the lockout delay after the next start pulse. The burst may finish after the next conversion has begun, provided it ends before that conversion's lockout point. An illegal setting raises a configuration error and keeps the block quiet. The first word after enabling is thrown away. Every later word is offered to the system through a valid/ready handshake.

Top module: `adc_echo_seq`

## Requirements
- R1: While enabled and the configuration is legal, `cnv_o` rises once every `cfg_period` cycles and stays high for exactly `cfg_pulse` cycles each time.
- R2: The first rising edge of `sclk_o` in a burst comes exactly `cfg_msb + 1` cycles after the most recent rising edge of `cnv_o`.
- R3: Each burst has exactly 16 pulses on `sclk_o`. Each pulse is high for `HALF` cycles, and the low gap between pulses is `HALF` cycles.
- R4: `sclk_o` stays low outside a burst, including during reset and while disabled.
- R5: The word is built MSB first. The bit taken on the first rising edge of `echo_clk_i` becomes bit 15, and the bit taken on the sixteenth becomes bit 0. Each bit is the value of `echo_dat_i` at that rising edge.
- R6: `cfg_err_o` is high when any of these holds: `cfg_pulse` is 0, `cfg_pulse` > `PW_MAX`, `cfg_pulse` >= `cfg_period`, `cfg_period` > `PERIOD_MAX`, `cfg_msb` >= `cfg_period`, or `cfg_msb + 1 + 32*HALF` > `cfg_period + cfg_lock`. While it is high, no conversion pulse and no burst are issued.
- R7: A configuration where `cfg_msb + 1 + 32*HALF` equals `cfg_period + cfg_lock` exactly is accepted and runs normally.
- R8: After `en` rises, the word from the first conversion is never offered. The word from the second conversion is the first one offered.
- R9: While `valid_o` is high and `ready_i` is low, `valid_o` and `word_o` hold. A word that completes in that time is dropped. The first word offered after the transfer comes from the conversion that completes next.
- R10: A burst that runs past the next rising edge of `cnv_o` carries on without disturbance. That next pulse still comes on time, and the word delivered is the one from the earlier conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run conversions while high |
| cfg_period | input | 16 | Conversion period in cycles |
| cfg_pulse | input | 16 | Conversion pulse high time in cycles |
| cfg_msb | input | 16 | Cycles from pulse start to MSB-ready |
| cfg_lock | input | 16 | Cycles after the next pulse start until lockout |
| cnv_o | output | 1 | Conversion start pulse |
| sclk_o | output | 1 | Gated burst clock to the converter |
| echo_clk_i | input | 1 | Clock returned by the converter |
| echo_dat_i | input | 1 | Serial data from the converter |
| cfg_err_o | output | 1 | Configuration is illegal |
| word_o | output | 16 | Captured result |
| valid_o | output | 1 | `word_o` holds an unread result |
| ready_i | input | 1 | System accepts the result |

## Verification
The case that needs care is a burst for one result still running when the next conversion pulse starts. With a period of 70, an MSB delay of 30 and a lockout of 40, the burst crosses the rising edge of the next pulse. The bench checks that this pulse still arrives on its 70-cycle grid. It also checks that the sixteen pulse widths stay exact and that the word delivered belongs to the conversion that began before the burst. Separately, a completion that arrives while the previous word is held under backpressure is shown to be dropped rather than to overwrite the held word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned CNT_W  = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        cnt_t period;
        cnt_t pulse;
        cnt_t msb;
        cnt_t lock;
    } seq_cfg_t;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_PULSE,
        FLT_PERIOD,
        FLT_MSB,
        FLT_FIT
    } cfg_fault_e;

    function automatic int unsigned burst_span(input int unsigned half);
        return 2 * WORD_W * half;
    endfunction

    function automatic cfg_fault_e cfg_check(input seq_cfg_t c,
                                             input int unsigned pw_max,
                                             input int unsigned period_max,
                                             input int unsigned span);
        logic [31:0] per, pw, msb, lck;
        per = 32'(c.period);
        pw  = 32'(c.pulse);
        msb = 32'(c.msb);
        lck = 32'(c.lock);
        if (pw == 32'd0 || pw > pw_max || pw >= per) return FLT_PULSE;
        if (per > period_max)                        return FLT_PERIOD;
        if (msb >= per)                              return FLT_MSB;
        if (msb + 32'd1 + span > per + lck)          return FLT_FIT;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/cnv_pacer.sv
module cnv_pacer
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  seq_cfg_t cfg,
    output logic     active,
    output logic     cnv,
    output logic     burst_start
);
    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else begin
            active <= run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt == cfg.period - cnt_t'(1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    assign cnv         = active && (cnt < cfg.pulse);
    assign burst_start = active && (cnt == cfg.msb);

    // R1: a new pulse only ever starts at the top of a period
    p_cnv_starts_period_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> (cnt == '0));

endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
    import adc_seq_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic start,
    output logic sclk
);
    localparam int unsigned HC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned PC_W = $clog2(WORD_W);

    logic            busy;
    logic [HC_W-1:0] hc;
    logic [PC_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            busy <= 1'b0;
            sclk <= 1'b0;
            hc   <= '0;
            pc   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                sclk <= 1'b1;
                hc   <= '0;
                pc   <= '0;
            end
        end else if (hc == HC_W'(HALF - 1)) begin
            hc   <= '0;
            sclk <= ~sclk;
            if (sclk) begin
                if (pc == PC_W'(WORD_W - 1)) begin
                    busy <= 1'b0;
                end else begin
                    pc <= pc + PC_W'(1);
                end
            end
        end else begin
            hc <= hc + HC_W'(1);
        end
    end

    // R4: clock parked low whenever no burst is running
    p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

endmodule

// File: rtl/echo_shift_in.sv
module echo_shift_in
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  echo_clk,
    input  logic  echo_dat,
    output logic  done,
    output word_t word
);
    localparam int unsigned BC_W = $clog2(WORD_W);

    logic            ck_s1, ck_s2, dat_s1;
    logic [BC_W-1:0] bc;
    word_t           sr;
    word_t           next_sr;

    assign next_sr = {sr[WORD_W-2:0], dat_s1};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ck_s1  <= 1'b0;
            ck_s2  <= 1'b0;
            dat_s1 <= 1'b0;
            sr     <= '0;
            bc     <= '0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            ck_s1  <= echo_clk;
            ck_s2  <= ck_s1;
            dat_s1 <= echo_dat;
            done   <= 1'b0;
            if (ck_s1 && !ck_s2) begin
                sr <= next_sr;
                if (bc == BC_W'(WORD_W - 1)) begin
                    bc   <= '0;
                    done <= 1'b1;
                    word <= next_sr;
                end else begin
                    bc <= bc + BC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/word_handoff.sv
module word_handoff
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  done,
    input  word_t word_in,
    input  logic  ready,
    output logic  valid,
    output word_t word_out
);
    logic first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pend <= 1'b1;
            valid      <= 1'b0;
            word_out   <= '0;
        end else begin
            if (!active) begin
                first_pend <= 1'b1;
            end
            if (active && done && first_pend) begin
                first_pend <= 1'b0;
                if (valid && ready) valid <= 1'b0;
            end else if (active && done && (!valid || ready)) begin
                valid    <= 1'b1;
                word_out <= word_in;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end

    // R9: an offered word stays put until taken
    p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(word_out)));

endmodule

// File: rtl/adc_echo_seq.sv
module adc_echo_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned HALF       = 2,
    parameter int unsigned PW_MAX     = 8,
    parameter int unsigned PERIOD_MAX = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [15:0] cfg_period,
    input  logic [15:0] cfg_pulse,
    input  logic [15:0] cfg_msb,
    input  logic [15:0] cfg_lock,
    output logic        cnv_o,
    output logic        sclk_o,
    input  logic        echo_clk_i,
    input  logic        echo_dat_i,
    output logic        cfg_err_o,
    output logic [15:0] word_o,
    output logic        valid_o,
    input  logic        ready_i
);
    localparam int unsigned SPAN = burst_span(HALF);

    seq_cfg_t   cfg;
    cfg_fault_e fault;
    logic       run, active, start, done;
    word_t      cap_word;

    assign cfg       = '{period: cfg_period, pulse: cfg_pulse, msb: cfg_msb, lock: cfg_lock};
    assign fault     = cfg_check(cfg, PW_MAX, PERIOD_MAX, SPAN);
    assign cfg_err_o = (fault != FLT_NONE);
    assign run       = en && !cfg_err_o;

    cnv_pacer u_pacer (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cfg         (cfg),
        .active      (active),
        .cnv         (cnv_o),
        .burst_start (start)
    );

    burst_clk_gen #(.HALF(HALF)) u_burst (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .start  (start),
        .sclk   (sclk_o)
    );

    echo_shift_in u_cap (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .echo_clk (echo_clk_i),
        .echo_dat (echo_dat_i),
        .done     (done),
        .word     (cap_word)
    );

    word_handoff u_hand (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .done     (done),
        .word_in  (cap_word),
        .ready    (ready_i),
        .valid    (valid_o),
        .word_out (word_o)
    );

    // R6: an illegal setting silences the conversion pulse
    p_no_cnv_on_err_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> !cnv_o);

endmodule

// File: tb/sim_adc_echo_seq.sv
module sim_adc_echo_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int PW_MAX     = 8;
    localparam int PERIOD_MAX = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] cfg_period = 16'd120, cfg_pulse = 16'd3, cfg_msb = 16'd10, cfg_lock = 16'd10;
    logic        cnv_o, sclk_o, cfg_err_o, valid_o;
    logic [15:0] word_o;
    logic        echo_clk_i, echo_dat_i = 1'b0;
    logic        ready_i = 1'b1;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign echo_clk_i = sclk_o;

    adc_echo_seq #(.HALF(HALF), .PW_MAX(PW_MAX), .PERIOD_MAX(PERIOD_MAX)) u0 (
        .clk(clk), .rst(rst), .en(en),
        .cfg_period(cfg_period), .cfg_pulse(cfg_pulse), .cfg_msb(cfg_msb), .cfg_lock(cfg_lock),
        .cnv_o(cnv_o), .sclk_o(sclk_o), .echo_clk_i(echo_clk_i), .echo_dat_i(echo_dat_i),
        .cfg_err_o(cfg_err_o), .word_o(word_o), .valid_o(valid_o), .ready_i(ready_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] word_of(input int k);
        return 16'((k * 4951 + 42165) & 16'hFFFF);
    endfunction

    // converter model: echoed clock is a copy of sclk; bits change on its fall
    int          ncnv = 0;
    int          bi = 0;
    logic [15:0] sh = '0;
    always @(posedge cnv_o) ncnv++;
    always @(posedge echo_clk_i) begin
        if (bi == 0) sh = word_of(ncnv - 1);
        echo_dat_i = sh[15 - bi];
    end
    always @(negedge echo_clk_i) begin
        bi++;
        if (bi == 16) bi = 0;
        else echo_dat_i = sh[15 - bi];
    end

    // handshake log
    logic [15:0] got [0:31];
    int          got_idx [0:31];
    int          gn = 0;

    // waveform monitor for R1..R3
    bit mon_on = 0;
    int e_period, e_pw, e_msb;
    bit cnv_p = 0, sclk_p = 0, have_rise = 0;
    int last_rise = 0, cw = 0, hi = 0, lo = 0, npulse = 0;

    always @(negedge clk) begin
        cyc++;
        if (valid_o && ready_i && gn < 32) begin
            got[gn] = word_o;
            got_idx[gn] = ncnv - 1;
            gn++;
        end
        if (mon_on) begin
            if (cnv_o && !cnv_p) begin
                if (have_rise) chk(cyc - last_rise == e_period, "R1 pulse spacing", cyc - last_rise, e_period);
                have_rise = 1;
                last_rise = cyc;
                cw = 0;
            end
            if (!cnv_o && cnv_p) chk(cw == e_pw, "R1 pulse width", cw, e_pw);
            if (cnv_o) cw++;
            if (sclk_o && !sclk_p) begin
                if (npulse == 0) chk(cyc - last_rise == e_msb + 1, "R2 burst start", cyc - last_rise, e_msb + 1);
                else chk(lo == HALF, "R3 low gap", lo, HALF);
                npulse++;
                hi = 0;
            end
            if (!sclk_o && sclk_p) begin
                chk(hi == HALF, "R3 high time", hi, HALF);
                lo = 0;
            end
            if (sclk_o) hi++;
            else begin
                lo++;
                if (npulse > 0 && lo == HALF + 1) begin
                    chk(npulse == 16, "R3 pulse count", npulse, 16);
                    npulse = 0;
                end
            end
        end
        cnv_p = cnv_o;
        sclk_p = sclk_o;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_run(input int p, input int w, input int m, input int l);
        cfg_period = 16'(p); cfg_pulse = 16'(w); cfg_msb = 16'(m); cfg_lock = 16'(l);
        e_period = p; e_pw = w; e_msb = m;
        have_rise = 0; npulse = 0; hi = 0; lo = 0; cw = 0;
        ncnv = 0; bi = 0; gn = 0;
        tick(1);
        mon_on = 1;
        en = 1'b1;
    endtask

    task automatic stop_run();
        mon_on = 0;
        en = 1'b0;
        tick(8);
    endtask

    task automatic wait_words(input int n, input int limit);
        int t = 0;
        while (gn < n && t < limit) begin tick(1); t++; end
        chk(gn >= n, "R8 words delivered", gn, n);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(4);
        chk(cnv_o == 1'b0, "R1 reset cnv", cnv_o, 0);
        chk(sclk_o == 1'b0, "R4 reset sclk", sclk_o, 0);
        chk(valid_o == 1'b0, "R9 reset valid", valid_o, 0);
        rst = 1'b0;
        tick(20);
        chk(sclk_o == 1'b0 && cnv_o == 1'b0, "R4 idle while disabled", sclk_o, 0);
    endtask

    task automatic t_words(input int p, input int w, input int m, input int l, input string tag);
        ready_i = 1'b1;
        start_run(p, w, m, l);
        chk(cfg_err_o == 1'b0, {tag, " legal config"}, cfg_err_o, 0);
        wait_words(4, 20 * p);
        for (int i = 0; i < 4; i++)
            chk(got[i] == word_of(i + 1), {tag, " R5 R8 word order"}, got[i], word_of(i + 1));
        stop_run();
    endtask

    task automatic t_backpressure();
        logic [15:0] held;
        int t;
        ready_i = 1'b0;
        start_run(120, 3, 10, 10);
        t = 0;
        while (!valid_o && t < 1000) begin tick(1); t++; end
        held = word_o;
        chk(held == word_of(1), "R8 first offered word", held, word_of(1));
        tick(360);
        chk(valid_o == 1'b1, "R9 valid held", valid_o, 1);
        chk(word_o == held, "R9 word held", word_o, held);
        ready_i = 1'b1;
        wait_words(2, 1000);
        chk(got[0] == held, "R9 held word transferred", got[0], held);
        chk(got[1] == word_of(got_idx[1]), "R9 fresh word after transfer", got[1], word_of(got_idx[1]));
        chk(got_idx[1] >= 4, "R9 held-time words dropped", got_idx[1], 4);
        stop_run();
    endtask

    task automatic t_bad(input int p, input int w, input int m, input int l, input string tag);
        int seen = 0;
        cfg_period = 16'(p); cfg_pulse = 16'(w); cfg_msb = 16'(m); cfg_lock = 16'(l);
        en = 1'b1;
        tick(2);
        chk(cfg_err_o == 1'b1, {"R6 error flag ", tag}, cfg_err_o, 1);
        for (int i = 0; i < 200; i++) begin
            if (cnv_o || sclk_o) seen++;
            tick(1);
        end
        chk(seen == 0, {"R6 quiet on error ", tag}, seen, 0);
        en = 1'b0;
        tick(4);
    endtask

    initial begin
        t_reset();
        t_words(120, 3, 10, 10, "basic");
        t_words(90, 5, 20, 0, "second timing");
        t_words(70, 2, 30, 40, "R10 overlap");
        t_backpressure();
        t_bad(120, 0, 10, 10, "zero pulse");
        t_bad(120, PW_MAX + 1, 10, 10, "wide pulse");
        t_bad(PERIOD_MAX + 1, 3, 10, 10, "long period");
        t_bad(120, 3, 120, 10, "msb past period");
        t_bad(120, 3, 60, 4, "no fit");
        t_bad(4, 4, 3, 64, "pulse fills period");
        t_words(120, 3, 60, 5, "R7 exact fit");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule